// File: doc/BRIEF.md
# Programmable Product-Term Plane

This block is the configurable AND plane of a small sum-of-products logic device. It takes a vector of array signals, made up of dedicated inputs and macrocell feedback. It presents each signal to the plane as a true column and a complement column. It then forms every product term combinationally as the AND of the columns that the term's stored connection row selects. The terms are gathered in fixed groups of eight, one group per output cell. For each group the block gives the OR of the first seven terms and, separately, the eighth term. The downstream cell can then either OR the eighth term into its sum or use it as an output enable.

The connection rows live in flops inside the block. A row is written whole through an address / row-data / write-strobe port, one row per clock. A global register-enable setting tells the plane whether the device uses registers. In that mode the two signals that share pins with the clock and the output enable are kept out of the data path.

Top module: `pal_and_plane`

## Requirements
- R1: After reset every connection bit is open, so every term, every group OR and every group eighth-term output is 1.
- R2: A term whose row has no connected column is 1 for any input.
- R3: Column 2*i is the true form of `sig_in[i]` and column 2*i+1 is its complement; a term with one connected column follows that column.
- R4: A term connected to both columns of a signal that is not withheld is 0 for any input.
- R5: A term is the AND of all its connected columns.
- R6: `grp_or[g]` is the OR of terms 8*g to 8*g+6.
- R7: `grp_last[g]` equals term 8*g+7.
- R8: With `regs_en` = 1, signals 0 and 13 (the shared clock and enable pins) are withheld: connections to either of their columns have no effect on a term.
- R9: With `regs_en` = 0, signals 0 and 13 act as ordinary array inputs.
- R10: A write whose address is 80 or more changes no row.
- R11: A write with `cfg_we` = 1 replaces the whole addressed row at the clock edge, and the terms reflect the new row from that edge on.
- R12: Terms and group outputs follow `sig_in` and `regs_en` within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the connection store |
| rst_n | input | 1 | Active-low synchronous reset; opens every connection |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 7 | Row (product term) index |
| cfg_row | input | 48 | Connection row; bit 2*i true, bit 2*i+1 complement of signal i |
| regs_en | input | 1 | 1: device uses registers, shared pins withheld |
| sig_in | input | 24 | Array signals (inputs and feedback) |
| term_out | output | 80 | All product terms |
| grp_or | output | 10 | OR of the first seven terms of each group |
| grp_last | output | 10 | Eighth term of each group |

## Verification
The hardest case to reach from the ports is a shared pin that is connected together with other columns while the register mode toggles. It only shows when a term's result depends on that pin alone. The stimulus writes rows that touch only signal 0 or 13, alone and paired with their complements, and flips `regs_en` while holding `sig_in`. A long random phase then mixes sparse rows, writes to out-of-range addresses and mode changes. A behavioural model checks every term and group output after each clock and again in mid-cycle after input changes.

// File: rtl/pal_plane_pkg.sv
package pal_plane_pkg;
    localparam int PAL_SIGS      = 24;
    localparam int PAL_TERMS     = 80;
    localparam int PAL_GRP_TERMS = 8;
    localparam int PAL_CLK_SIG   = 0;
    localparam int PAL_OE_SIG    = 13;

    function automatic int true_col(input int sig);
        return 2 * sig;
    endfunction

    function automatic int comp_col(input int sig);
        return 2 * sig + 1;
    endfunction
endpackage

// File: rtl/pal_mask_store.sv
module pal_mask_store #(
    parameter int TERMS = 80,
    parameter int COLS  = 48,
    localparam int AW   = $clog2(TERMS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [COLS-1:0]       row_in,
    output logic [TERMS*COLS-1:0] mask_flat
);
    logic [COLS-1:0] rows [TERMS];
    logic            hit;

    assign hit = we && (int'(addr) < TERMS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TERMS; r++) rows[r] <= '0;
        end else if (hit) begin
            rows[addr] <= row_in;
        end
    end

    for (genvar r = 0; r < TERMS; r++) begin : g_flat
        assign mask_flat[r*COLS +: COLS] = rows[r];
    end

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) >= TERMS) |=> $stable(mask_flat)); // R10

    AST_ROW_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) < TERMS) |=> (rows[$past(addr)] == $past(row_in))); // R11
endmodule

// File: rtl/pal_term_eval.sv
module pal_term_eval #(
    parameter int SIGS  = 24,
    parameter int TERMS = 80,
    parameter logic [SIGS-1:0] SHARED = '0,
    localparam int COLS = 2 * SIGS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  regs_en,
    input  logic [SIGS-1:0]       sig_in,
    input  logic [TERMS*COLS-1:0] mask_flat,
    output logic [TERMS-1:0]      term
);
    import pal_plane_pkg::*;

    logic [COLS-1:0] col;
    logic [SIGS-1:0] held;

    assign held = regs_en ? SHARED : '0;

    for (genvar i = 0; i < SIGS; i++) begin : g_col
        assign col[true_col(i)] = held[i] | sig_in[i];
        assign col[comp_col(i)] = held[i] | ~sig_in[i];
    end

    for (genvar k = 0; k < TERMS; k++) begin : g_term
        logic [COLS-1:0] m;
        logic [SIGS-1:0] clash;
        assign m       = mask_flat[k*COLS +: COLS];
        assign term[k] = &(col | ~m);

        for (genvar i = 0; i < SIGS; i++) begin : g_clash
            assign clash[i] = m[true_col(i)] & m[comp_col(i)] & ~held[i];
        end

        AST_EMPTY_ROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (m == '0) |-> term[k]); // R2

        AST_CLASH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (clash != '0) |-> !term[k]); // R4
    end
endmodule

// File: rtl/pal_group_tap.sv
module pal_group_tap #(
    parameter int TERMS     = 80,
    parameter int GRP_TERMS = 8,
    localparam int GROUPS   = TERMS / GRP_TERMS
) (
    input  logic [TERMS-1:0]  term,
    output logic [GROUPS-1:0] grp_or,
    output logic [GROUPS-1:0] grp_last
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_or[g]   = |term[g*GRP_TERMS +: GRP_TERMS-1];
        assign grp_last[g] = term[g*GRP_TERMS + GRP_TERMS-1];
    end
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
    import pal_plane_pkg::*;
#(
    parameter int SIGS      = PAL_SIGS,
    parameter int TERMS     = PAL_TERMS,
    parameter int GRP_TERMS = PAL_GRP_TERMS,
    parameter int CLK_SIG   = PAL_CLK_SIG,
    parameter int OE_SIG    = PAL_OE_SIG,
    localparam int COLS     = 2 * SIGS,
    localparam int GROUPS   = TERMS / GRP_TERMS,
    localparam int AW       = $clog2(TERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [COLS-1:0]   cfg_row,
    input  logic              regs_en,
    input  logic [SIGS-1:0]   sig_in,
    output logic [TERMS-1:0]  term_out,
    output logic [GROUPS-1:0] grp_or,
    output logic [GROUPS-1:0] grp_last
);
    localparam logic [SIGS-1:0] SHARED =
        (SIGS'(1) << CLK_SIG) | (SIGS'(1) << OE_SIG);

    logic [TERMS*COLS-1:0] mask_flat;

    pal_mask_store #(.TERMS(TERMS), .COLS(COLS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .row_in(cfg_row), .mask_flat(mask_flat)
    );

    pal_term_eval #(.SIGS(SIGS), .TERMS(TERMS), .SHARED(SHARED)) u_eval (
        .clk(clk), .rst_n(rst_n), .regs_en(regs_en), .sig_in(sig_in),
        .mask_flat(mask_flat), .term(term_out)
    );

    pal_group_tap #(.TERMS(TERMS), .GRP_TERMS(GRP_TERMS)) u_grp (
        .term(term_out), .grp_or(grp_or), .grp_last(grp_last)
    );

    AST_RESET_OPENS_ALL: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (term_out == '1))); // R1
endmodule

// File: tb/pal_and_plane_test.sv
module pal_and_plane_test;
    localparam int SIGS = 24, TERMS = 80, COLS = 48, GROUPS = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [6:0]        cfg_addr = '0;
    logic [COLS-1:0]   cfg_row = '0;
    logic              regs_en = 1'b0;
    logic [SIGS-1:0]   sig_in = '0;
    logic [TERMS-1:0]  term_out;
    logic [GROUPS-1:0] grp_or, grp_last;

    int n_cmp = 0, n_bad = 0;
    logic [COLS-1:0] model [TERMS];

    pal_and_plane uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_row(cfg_row), .regs_en(regs_en), .sig_in(sig_in),
        .term_out(term_out), .grp_or(grp_or), .grp_last(grp_last)
    );

    always #2.5 clk = ~clk;

    // Reference store: whole-row writes, out-of-range ignored.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TERMS; r++) model[r] = '0;
        end else if (cfg_we && cfg_addr < 7'd80) begin
            model[cfg_addr] = cfg_row;
        end
    end

    function automatic logic ref_term(input int k);
        logic v = 1'b1;
        for (int i = 0; i < SIGS; i++) begin
            if (regs_en && (i == 0 || i == 13)) continue;
            if (model[k][2*i] && !sig_in[i]) v = 1'b0;
            if (model[k][2*i+1] && sig_in[i]) v = 1'b0;
        end
        return v;
    endfunction

    task automatic compare(input string tag);
        logic [TERMS-1:0] e;
        for (int k = 0; k < TERMS; k++) e[k] = ref_term(k);
        n_cmp++;
        if (term_out !== e) begin
            n_bad++;
            $display("FAIL %s terms got %h exp %h", tag, term_out, e);
        end
        for (int g = 0; g < GROUPS; g++) begin
            n_cmp += 2;
            if (grp_or[g] !== |e[g*8 +: 7]) begin
                n_bad++;
                $display("FAIL R6 (%s) grp_or[%0d] got %b exp %b", tag, g, grp_or[g], |e[g*8 +: 7]);
            end
            if (grp_last[g] !== e[g*8+7]) begin
                n_bad++;
                $display("FAIL R7 (%s) grp_last[%0d] got %b exp %b", tag, g, grp_last[g], e[g*8+7]);
            end
        end
    endtask

    // drive a write for one clock, then compare after the edge
    task automatic wr(input int a, input logic [COLS-1:0] row, input string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_row = row;
        @(negedge clk);
        cfg_we = 1'b0;
        compare(tag);
    endtask

    // change inputs mid-cycle and compare without any clock edge
    task automatic poke(input logic [SIGS-1:0] s, input logic re, input string tag);
        sig_in = s; regs_en = re;
        #1;
        compare(tag);
    endtask

    function automatic logic [COLS-1:0] tcol(input int i);
        return COLS'(1) << (2*i);
    endfunction
    function automatic logic [COLS-1:0] ccol(input int i);
        return COLS'(1) << (2*i+1);
    endfunction

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        poke(24'hA5F00F, 1'b0, "R2 empty rows");
        poke(24'h5A0FF0, 1'b1, "R2 empty rows regs");

        // R3: single true, single complement column
        wr(5, tcol(3), "R3 true col");
        poke(24'h000008, 1'b0, "R3 true high");
        poke(24'h000000, 1'b0, "R3 true low");
        wr(6, ccol(3) | tcol(7), "R5 comp and true");
        for (int v = 0; v < 4; v++)
            poke(24'((v & 1) << 3 | (v >> 1) << 7), 1'b0, "R5 pair sweep");
        // R4: clash
        wr(9, tcol(2) | ccol(2), "R4 clash");
        poke(24'hFFFFFF, 1'b0, "R4 clash ones");
        poke(24'h000000, 1'b1, "R4 clash zeros");
        // R6/R7 group 1
        for (int k = 8; k < 15; k++) wr(k, tcol(4) | ccol(4), "R6 fill group");
        wr(15, tcol(1), "R7 eighth term");
        poke(24'h000002, 1'b0, "R7 eighth high");
        poke(24'h000000, 1'b0, "R7 eighth low");
        wr(12, tcol(9), "R6 one term live");
        poke(24'h000200, 1'b0, "R6 or high");
        // R8/R9 shared pins
        wr(20, tcol(0), "R9 clk col");
        wr(21, ccol(13), "R9 oe col");
        wr(22, tcol(0) | ccol(0), "R8 clk clash");
        wr(23, tcol(13) | tcol(5), "R8 oe with other");
        for (int v = 0; v < 8; v++) begin
            logic [SIGS-1:0] s = 24'((v & 1) | ((v >> 1 & 1) << 13) | ((v >> 2) << 5));
            poke(s, 1'b1, "R8 withheld");
            poke(s, 1'b0, "R9 as data");
        end
        // R10: out-of-range writes
        wr(80, '1, "R10 addr 80");
        wr(127, '1, "R10 addr 127");
        wr(100, '0, "R10 addr 100");
        poke(24'h123456, 1'b0, "R10 rows kept");
        // R11: overwrite replaces row
        wr(5, '0, "R11 row cleared");
        wr(79, ccol(23), "R11 last row");
        poke(24'h800000, 1'b0, "R11 last row low");
        // random phase
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            compare("R11 random");
            cfg_we   = ($urandom_range(0, 2) != 0);
            cfg_addr = 7'($urandom_range(0, 127));
            cfg_row  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                       & {$urandom, $urandom};
            regs_en  = 1'($urandom);
            sig_in   = 24'($urandom);
            #1;
            compare("R12 random comb");
        end
        @(negedge clk);
        cfg_we = 1'b0;
        compare("R11 final");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule